// File: doc/BRIEF.md
# Tile Row Pixel Fetcher

This block turns one row of an 8x8 tile, stored at 4 bits per pixel, into a stream of eight 24-bit RGB pixels. A single start pulse supplies the pattern base address, the row number inside the tile, a palette number and the two mirror flags. The block then walks the four pattern bytes of the selected row, picks one nibble per pixel, looks that colour up in colour memory and widens the stored colour word into a byte-per-channel RGB value.

Both memories sit outside the block and answer a read two clock cycles after the address is presented. Pattern reads come out one per cycle. Each colour index returned drives a colour-memory read in the same cycle, and the pixel is registered on the next edge, so the block produces one pixel per clock once the pipeline has filled. A start that arrives on the last fetch cycle of a row chains the next row with no gap in the output. A colour index of zero is reported on a separate flag so that a later stage can treat it as see-through.

Top module: `tile_row_fetch`

## Requirements
- R1: While `rst` is high and afterwards until a start is accepted, `pix_valid`, `pix_clear`, `vram_rd`, `cram_rd` and `busy` stay low.
- R2: When `start` is sampled and accepted on a rising edge, pixel 0 is valid after the fifth rising edge that follows it. Pixels 1 to 7 follow on the next seven edges with no gap.
- R3: For pixel p of the row, the pattern byte address is `base + 4*r + c` modulo 2^VRAM_AW. Here r is `line`, or 7-`line` when `vflip` is set, and c is p/2, or 3-p/2 when `hflip` is set. Each byte is read on two consecutive cycles.
- R4: Without `hflip`, even pixels take bits 7:4 of their pattern byte and odd pixels take bits 3:0. With `hflip` the two are swapped.
- R5: The colour memory byte address is `(palette*16 + colour)*2` and is always even. `cram_word` carries the low 12 bits of the big-endian word stored there: byte address a supplies bits 11:8 from its low nibble, and byte a+1 supplies bits 7:0.
- R6: `pix_rgb` is `{w[3:0],4'h0, w[7:4],4'h0, w[11:8],4'h0}` for colour word w.
- R7: `pix_clear` is high, together with `pix_valid`, exactly for pixels whose colour index is 0. Such pixels still carry the looked-up `pix_rgb`.
- R8: A `start` sampled while a row is being fetched is ignored, except on the row's last fetch cycle. An ignored start produces no extra memory read and no extra pixel.
- R9: A `start` sampled on the last fetch cycle of a row is accepted. The new row's first pattern read follows on the next cycle, and its pixels follow the previous row's with no gap.
- R10: Every accepted row asserts `vram_rd` on exactly 8 cycles and `cram_rd` on exactly 8 cycles. Each `cram_rd` comes two cycles after its `vram_rd`, and the pixel comes three cycles after its `cram_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to fetch one tile row |
| base | input | VRAM_AW | Pattern base byte address |
| line | input | 3 | Row inside the tile |
| pal | input | PAL_W | Palette number |
| hflip | input | 1 | Mirror left to right |
| vflip | input | 1 | Mirror top to bottom |
| busy | output | 1 | High on the eight fetch cycles of a row |
| vram_rd | output | 1 | Pattern memory read strobe |
| vram_addr | output | VRAM_AW | Pattern memory byte address |
| vram_data | input | 8 | Pattern byte, two cycles after the address |
| cram_rd | output | 1 | Colour memory read strobe |
| cram_addr | output | PAL_W+5 | Colour memory byte address |
| cram_word | input | 12 | Colour word, two cycles after the address |
| pix_valid | output | 1 | Pixel output valid |
| pix_rgb | output | 24 | Packed RGB pixel |
| pix_clear | output | 1 | Pixel has colour index 0 |

## Verification
The bench builds the block with VRAM_AW=10 and PAL_W=2. This gives a 1 KiB pattern memory, so random base addresses often carry the row past the top of the address space and exercise the wrap in R3. It also gives a colour memory small enough that all four palettes are hit many times. Random rows with random gaps of zero to three idle cycles reach back-to-back chaining, and directed rows cover all four mirror combinations at lines 0 and 7, zero nibbles, and a start dropped in the middle of a row.

// File: rtl/tile_row_fetch.sv
module tile_row_fetch #(
  parameter int VRAM_AW = 16,
  parameter int PAL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [VRAM_AW-1:0] base,
  input  logic [2:0]         line,
  input  logic [PAL_W-1:0]   pal,
  input  logic               hflip,
  input  logic               vflip,
  output logic               busy,
  output logic               vram_rd,
  output logic [VRAM_AW-1:0] vram_addr,
  input  logic [7:0]         vram_data,
  output logic               cram_rd,
  output logic [PAL_W+4:0]   cram_addr,
  input  logic [11:0]        cram_word,
  output logic               pix_valid,
  output logic [23:0]        pix_rgb,
  output logic               pix_clear
);
  localparam int PAD_ROW = VRAM_AW - 5;
  localparam int PAD_COL = VRAM_AW - 2;

  logic               busy_q;
  logic [2:0]         idx_q;
  logic [VRAM_AW-1:0] row_base_q;
  logic [PAL_W-1:0]   pal_q;
  logic               hflip_q;

  logic               s1_v, s2_v, s3_v, s4_v;
  logic               s1_hi, s2_hi;
  logic [PAL_W-1:0]   s1_pal, s2_pal;
  logic               s3_clr, s4_clr;

  logic       last;
  logic       accept;
  logic [2:0] row;
  logic [1:0] bcol;
  logic [3:0] colour;

  assign last   = idx_q == 3'd7;
  assign accept = start && (!busy_q || last);
  assign row    = line ^ {3{vflip}};
  assign bcol   = idx_q[2:1] ^ {2{hflip_q}};

  assign busy      = busy_q;
  assign vram_rd   = busy_q;
  assign vram_addr = row_base_q + {{PAD_COL{1'b0}}, bcol};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      row_base_q <= '0;
      pal_q      <= '0;
      hflip_q    <= 1'b0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      idx_q      <= '0;
      row_base_q <= base + {{PAD_ROW{1'b0}}, row, 2'b00};
      pal_q      <= pal;
      hflip_q    <= hflip;
    end else if (busy_q) begin
      idx_q <= idx_q + 3'd1;
      if (last) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s1_hi  <= 1'b0;
      s2_hi  <= 1'b0;
      s1_pal <= '0;
      s2_pal <= '0;
    end else begin
      s1_v   <= busy_q;
      s2_v   <= s1_v;
      s1_hi  <= ~(idx_q[0] ^ hflip_q);
      s2_hi  <= s1_hi;
      s1_pal <= pal_q;
      s2_pal <= s1_pal;
    end
  end

  assign colour    = s2_hi ? vram_data[7:4] : vram_data[3:0];
  assign cram_rd   = s2_v;
  assign cram_addr = {s2_pal, colour, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_v      <= 1'b0;
      s4_v      <= 1'b0;
      s3_clr    <= 1'b0;
      s4_clr    <= 1'b0;
      pix_valid <= 1'b0;
      pix_clear <= 1'b0;
      pix_rgb   <= '0;
    end else begin
      s3_v      <= s2_v;
      s4_v      <= s3_v;
      s3_clr    <= colour == 4'd0;
      s4_clr    <= s3_clr;
      pix_valid <= s4_v;
      pix_clear <= s4_v && s4_clr;
      pix_rgb   <= {cram_word[3:0], 4'h0, cram_word[7:4], 4'h0, cram_word[11:8], 4'h0};
    end
  end
endmodule

// File: rtl/tile_row_fetch_chk.sv
module tile_row_fetch_chk #(
  parameter int VRAM_AW = 16,
  parameter int PAL_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               vram_rd,
  input logic [VRAM_AW-1:0] vram_addr,
  input logic               cram_rd,
  input logic [PAL_W+4:0]   cram_addr,
  input logic               pix_valid,
  input logic               pix_clear
);
  logic odd_q;

  always_ff @(posedge clk) begin
    if (rst) odd_q <= 1'b0;
    else if (vram_rd) odd_q <= ~odd_q;
  end

  assert_byte_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (odd_q && vram_rd) |-> ($past(vram_rd) && vram_addr == $past(vram_addr)));

  assert_cram_even_R5: assert property (@(posedge clk) disable iff (rst)
    cram_rd |-> cram_addr[0] == 1'b0);

  assert_clear_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    pix_clear |-> pix_valid);

  assert_cram_after_vram_R10: assert property (@(posedge clk) disable iff (rst)
    vram_rd |-> ##2 cram_rd);

  assert_pixel_after_cram_R2: assert property (@(posedge clk) disable iff (rst)
    cram_rd |-> ##3 pix_valid);
endmodule

bind tile_row_fetch tile_row_fetch_chk #(.VRAM_AW(VRAM_AW), .PAL_W(PAL_W)) chk_i (
  .clk(clk), .rst(rst), .vram_rd(vram_rd), .vram_addr(vram_addr),
  .cram_rd(cram_rd), .cram_addr(cram_addr),
  .pix_valid(pix_valid), .pix_clear(pix_clear)
);

// File: tb/tile_row_fetch_tb_top.sv
module tile_row_fetch_tb_top;
  localparam int VA = 10;
  localparam int PW = 2;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [VA-1:0] base = '0;
  logic [2:0] line = '0;
  logic [PW-1:0] pal = '0;
  logic hflip = 1'b0, vflip = 1'b0;
  logic busy, vram_rd, cram_rd, pix_valid, pix_clear;
  logic [VA-1:0] vram_addr;
  logic [PW+4:0] cram_addr;
  logic [7:0] vram_data;
  logic [11:0] cram_word;
  logic [23:0] pix_rgb;

  always #5 clk = ~clk;

  tile_row_fetch #(.VRAM_AW(VA), .PAL_W(PW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base(base), .line(line), .pal(pal),
    .hflip(hflip), .vflip(vflip), .busy(busy), .vram_rd(vram_rd),
    .vram_addr(vram_addr), .vram_data(vram_data), .cram_rd(cram_rd),
    .cram_addr(cram_addr), .cram_word(cram_word), .pix_valid(pix_valid),
    .pix_rgb(pix_rgb), .pix_clear(pix_clear)
  );

  logic [7:0] vmem [0:(1<<VA)-1];
  logic [7:0] cmem [0:(1<<(PW+5))-1];
  logic [7:0] vd1, vd2;
  logic [15:0] cw1, cw2;

  always @(posedge clk) begin
    vd1 <= vmem[vram_addr];
    vd2 <= vd1;
    cw1 <= {cmem[cram_addr], cmem[{cram_addr[PW+4:1], 1'b1}]};
    cw2 <= cw1;
  end
  assign vram_data = vd2;
  assign cram_word = cw2[11:0];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, rows = 0, nv = 0, nc = 0;
  bit done = 1'b0;

  int pe_cyc [0:QN-1];
  logic [23:0] pe_rgb [0:QN-1];
  logic pe_clr [0:QN-1];
  int ph = 0, pt = 0;
  int ae_cyc [0:QN-1];
  logic [VA-1:0] ae_addr [0:QN-1];
  int ah = 0, at = 0;

  function automatic logic [VA-1:0] exp_addr(input logic [VA-1:0] b, input logic [2:0] ln,
                                             input logic h, input logic v, input int p);
    logic [2:0] r;
    logic [1:0] c;
    r = v ? 3'd7 - ln : ln;
    c = h ? 2'(3 - p / 2) : 2'(p / 2);
    return b + VA'(r) * VA'(4) + VA'(c);
  endfunction

  function automatic logic [3:0] exp_colour(input logic [7:0] d, input logic h, input int p);
    logic hi;
    hi = ((p % 2) == 0) != h;
    return hi ? d[7:4] : d[3:0];
  endfunction

  function automatic logic [23:0] exp_rgb(input logic [15:0] w);
    return {w[3:0], 4'h0, w[7:4], 4'h0, w[11:8], 4'h0};
  endfunction

  task automatic drive(input logic [VA-1:0] b, input logic [2:0] ln, input logic [PW-1:0] pl,
                       input logic h, input logic v, input bit expect_take);
    base = b; line = ln; pal = pl; hflip = h; vflip = v; start = 1'b1;
    if (expect_take) begin
      rows++;
      for (int p = 0; p < 8; p++) begin
        logic [VA-1:0] a;
        logic [3:0] col;
        int ci;
        a = exp_addr(b, ln, h, v, p);
        col = exp_colour(vmem[a], h, p);
        ci = int'(pl) * 16 + int'(col);
        ae_cyc[at] = cyc + 1 + p; ae_addr[at] = a; at++;
        pe_cyc[pt] = cyc + 6 + p;
        pe_rgb[pt] = exp_rgb({cmem[ci * 2], cmem[ci * 2 + 1]});
        pe_clr[pt] = (col == 4'd0);
        pt++;
      end
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (vram_rd) nv++;
      if (cram_rd) nc++;
      if (ah < at && ae_cyc[ah] == cyc) begin
        total++;
        if (!vram_rd || vram_addr !== ae_addr[ah]) begin
          bad++;
          $display("FAIL R3 pattern read: rd=%0b addr=%h expected rd=1 addr=%h", vram_rd, vram_addr, ae_addr[ah]);
        end
        ah++;
      end else if (vram_rd) begin
        total++; bad++;
        $display("FAIL R8 unexpected pattern read: addr=%h expected no read", vram_addr);
      end
      if (ph < pt && pe_cyc[ph] == cyc) begin
        total++;
        if (!pix_valid) begin
          bad++;
          $display("FAIL R2 pixel timing: valid=%0b expected 1 at cycle %0d", pix_valid, cyc);
        end else begin
          total++;
          if (pix_rgb !== pe_rgb[ph]) begin
            bad++;
            $display("FAIL R4 R5 R6 pixel colour: rgb=%h expected %h", pix_rgb, pe_rgb[ph]);
          end
          total++;
          if (pix_clear !== pe_clr[ph]) begin
            bad++;
            $display("FAIL R7 clear flag: clear=%0b expected %0b", pix_clear, pe_clr[ph]);
          end
        end
        ph++;
      end else if (pix_valid) begin
        total++; bad++;
        $display("FAIL R8 unexpected pixel: valid=1 rgb=%h expected no pixel", pix_rgb);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    for (int i = 0; i < (1 << VA); i++) vmem[i] = 8'($urandom);
    for (int i = 0; i < (1 << (PW + 5)); i++) cmem[i] = 8'($urandom);
    vmem[0] = 8'h0F; vmem[1] = 8'hF0; vmem[2] = 8'h00; vmem[3] = 8'h50;
    vmem[28] = 8'h12; vmem[29] = 8'h34; vmem[30] = 8'h56; vmem[31] = 8'h78;
    cmem[0] = 8'h0E; cmem[1] = 8'hA4;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    total++;
    if (pix_valid || pix_clear || vram_rd || cram_rd || busy) begin
      bad++;
      $display("FAIL R1 idle after reset: v=%0b c=%0b vr=%0b cr=%0b b=%0b expected all 0",
               pix_valid, pix_clear, vram_rd, cram_rd, busy);
    end

    // R4 R7: zero nibbles at line 0, all mirror combinations at lines 0 and 7
    for (int f = 0; f < 4; f++) begin
      drive('0, 3'd0, '0, f[0], f[1], 1'b1);
      repeat (9) @(negedge clk);
      drive(VA'(4), 3'd7, 2'd3, f[0], f[1], 1'b1);
      repeat (9) @(negedge clk);
    end

    // R3: row runs past the top of pattern memory
    drive(VA'((1 << VA) - 6), 3'd1, 2'd2, 1'b0, 1'b0, 1'b1);
    repeat (9) @(negedge clk);

    // R8: start in the middle of a row is dropped
    drive(VA'(100), 3'd2, 2'd1, 1'b1, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    drive(VA'(500), 3'd5, 2'd2, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);

    // R9: start on the last fetch cycle chains rows back to back
    drive(VA'(200), 3'd3, 2'd1, 1'b0, 1'b0, 1'b1);
    repeat (7) @(negedge clk);
    drive(VA'(300), 3'd6, 2'd3, 1'b1, 1'b1, 1'b1);
    repeat (7) @(negedge clk);
    drive(VA'(400), 3'd4, 2'd0, 1'b1, 1'b0, 1'b1);
    repeat (9) @(negedge clk);

    for (int n = 0; n < 300; n++) begin
      drive(VA'($urandom), 3'($urandom), PW'($urandom), 1'($urandom), 1'($urandom), 1'b1);
      if ($urandom_range(0, 5) == 0) begin
        repeat (1 + $urandom_range(0, 4)) @(negedge clk);
        drive(VA'($urandom), 3'($urandom), PW'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        repeat (6 - 1) @(negedge clk);
      end else begin
        repeat (7 + $urandom_range(0, 3)) @(negedge clk);
      end
    end
    repeat (12) @(negedge clk);

    total++;
    if (ph != pt || ah != at) begin
      bad++;
      $display("FAIL R2 missing output: pixels=%0d reads=%0d expected %0d %0d", ph, ah, pt, at);
    end
    total++;
    if (nv != rows * 8 || nc != rows * 8) begin
      bad++;
      $display("FAIL R10 strobe count: vram_rd=%0d cram_rd=%0d expected %0d", nv, nc, rows * 8);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule